// File: doc/BRIEF.md
# Flash-to-DRAM Word DMA with Running Checksum

This engine copies data between a flash address space and a DRAM address space one 32-bit word at a time. Software sets a flash address, a DRAM address split into a 32-bit low part and a 4-bit high part, and a byte length through a small register port. It then writes a control word whose go bit starts the run. The direction is either flash to DRAM (read) or DRAM to flash (write). A third mode reads flash words only and accumulates them without storing anything.

Each side has its own single-word request/acknowledge port. Only one access is outstanding at a time. Every word read is added into a 32-bit checksum. While the run proceeds, the address and length registers hold the live position. A done flag reports completion, and an error flag reports an illegal mode or a failed access.

Top module: `fdma_engine`

## Requirements
- R1: After reset, every register reads zero: status, flash address, DRAM low, DRAM high, length and checksum. No memory request is raised.
- R2: Register write masks. The flash address (select 1) and DRAM low (select 2) clear their two low bits. DRAM high (select 3) keeps bits [3:0]. Length (select 4) keeps bits [24:0].
- R3: A run moves ceil((length + START_LEN) / 4) words, where START_LEN is a parameter of 1 or 4. With START_LEN=1, a length of 0 moves one word and a length of 4 moves two.
- R4: With control bit 1 clear and bit 0 clear, word i is read from flash address A+4i and written to DRAM address D+4i. Flash and DRAM are never requested in the same cycle.
- R5: With control bit 1 set, word i is read from DRAM address D+4i and written to flash address A+4i.
- R6: With control bit 0 set and bit 1 clear (checksum mode), words are read from flash only. DRAM is never accessed and the DRAM address is left unchanged.
- R7: The checksum register (select 5) holds the sum, modulo 2^32, of every word read since the last go. Writing go clears it.
- R8: After each completed word, the flash address and, when DRAM is used, the DRAM address advance by 4. The length register then holds the bytes still to move, and it reads 0 at the end.
- R9: The DRAM address is incremented as one 36-bit value, so a carry out of the low 32 bits increments the high register.
- R10: Status (select 0) reads bit 31 busy, bit 9 error, bit 8 done, bit 1 direction and bit 0 checksum mode. Done sets when the last word completes, and writing go clears done and error.
- R11: A go with both bit 1 and bit 0 set is illegal. It sets the error flag, starts no run and issues no memory request.
- R12: An access acknowledged with its error input set aborts the run. The error flag sets, done stays clear, the failed word is not stored, and the registers keep the values from the last completed word.
- R13: While busy, writes to any register are ignored. This includes a second go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wsel | input | 3 | Register select for the write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rsel | input | 3 | Register select for the read |
| cfg_rdata | output | 32 | Register read data (combinational) |
| fl_req | output | 1 | Flash access request, held until acknowledged |
| fl_we | output | 1 | Flash access is a write |
| fl_addr | output | 32 | Flash word address |
| fl_wdata | output | 32 | Flash write data |
| fl_ack | input | 1 | Flash access complete |
| fl_err | input | 1 | Flash access failed (valid with fl_ack) |
| fl_rdata | input | 32 | Flash read data (valid with fl_ack) |
| dr_req | output | 1 | DRAM access request, held until acknowledged |
| dr_we | output | 1 | DRAM access is a write |
| dr_addr | output | 36 | DRAM word address, high bits above low bits |
| dr_wdata | output | 32 | DRAM write data |
| dr_ack | input | 1 | DRAM access complete |
| dr_err | input | 1 | DRAM access failed (valid with dr_ack) |
| dr_rdata | input | 32 | DRAM read data (valid with dr_ack) |

## Verification
A wrong remaining-byte count is visible as soon as the first word completes. The length register then skips a value, and the run ends with the wrong final address. A fault in the fetch/store sequencing puts data at the wrong destination index, or raises a request on the wrong side within the first two cycles of the run. A lost carry in the DRAM increment shows up at the 4 GB wrap as a high register that does not move. Abort handling errors appear one cycle after the failing acknowledge, as a busy flag that stays set or a length that has moved.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_FLASH = 3'd1,
    SEL_DLO   = 3'd2,
    SEL_DHI   = 3'd3,
    SEL_LEN   = 3'd4,
    SEL_SUM   = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_STORE = 2'd2
  } phase_e;

  localparam int CTL_GO   = 31;
  localparam int CTL_WR   = 1;
  localparam int CTL_SUM  = 0;
  localparam int ST_BUSY  = 31;
  localparam int ST_ERR   = 9;
  localparam int ST_DONE  = 8;
endpackage

// File: rtl/fdma_wordcount.sv
module fdma_wordcount #(
  parameter int LEN_W     = 25,
  parameter int START_LEN = 1
) (
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W:0]   bytes_o
);
  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] biased;

  generate
    if ((START_LEN % 4) == 0) begin : g_aligned
      // bias keeps word alignment: only the programmed remainder rounds
      assign biased  = {1'b0, len_i} + CNT_W'(START_LEN);
      assign bytes_o = (biased + CNT_W'(3)) & ~CNT_W'(3);
    end else begin : g_unaligned
      assign biased  = {1'b0, len_i} + CNT_W'(START_LEN);
      assign bytes_o = (biased + CNT_W'(3)) & ~CNT_W'(3);
    end
  endgenerate
endmodule

// File: rtl/fdma_addr_step.sv
module fdma_addr_step #(
  parameter int ADDR_W = 32,
  parameter int HI_W   = 4,
  parameter int STEP   = 4
) (
  input  logic [HI_W-1:0]   hi_i,
  input  logic [ADDR_W-1:0] lo_i,
  output logic [HI_W-1:0]   hi_o,
  output logic [ADDR_W-1:0] lo_o
);
  localparam int FULL_W = HI_W + ADDR_W;

  logic [FULL_W-1:0] sum;

  assign sum  = {hi_i, lo_i} + FULL_W'(STEP);
  assign lo_o = sum[ADDR_W-1:0];
  assign hi_o = sum[FULL_W-1:ADDR_W];
endmodule

// File: rtl/fdma_seq.sv
module fdma_seq
  import fdma_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   sum_only,
  input  logic   last,
  input  logic   src_ack,
  input  logic   src_err,
  input  logic   dst_ack,
  input  logic   dst_err,
  output phase_e phase_o,
  output logic   fetch_ok_o,
  output logic   step_o,
  output logic   abort_o
);
  phase_e ph_q, ph_n;

  always_comb begin
    ph_n       = ph_q;
    fetch_ok_o = 1'b0;
    step_o     = 1'b0;
    abort_o    = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) ph_n = PH_FETCH;
      end
      PH_FETCH: begin
        if (src_ack) begin
          if (src_err) begin
            abort_o = 1'b1;
            ph_n    = PH_IDLE;
          end else begin
            fetch_ok_o = 1'b1;
            if (sum_only) begin
              step_o = 1'b1;
              ph_n   = last ? PH_IDLE : PH_FETCH;
            end else begin
              ph_n = PH_STORE;
            end
          end
        end
      end
      PH_STORE: begin
        if (dst_ack) begin
          if (dst_err) begin
            abort_o = 1'b1;
            ph_n    = PH_IDLE;
          end else begin
            step_o = 1'b1;
            ph_n   = last ? PH_IDLE : PH_FETCH;
          end
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_n;
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/fdma_engine.sv
module fdma_engine
  import fdma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int HI_W      = 4,
  parameter int LEN_W     = 25,
  parameter int DATA_W    = 32,
  parameter int START_LEN = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [2:0]             cfg_wsel,
  input  logic [31:0]            cfg_wdata,
  input  logic [2:0]             cfg_rsel,
  output logic [31:0]            cfg_rdata,
  output logic                   fl_req,
  output logic                   fl_we,
  output logic [ADDR_W-1:0]      fl_addr,
  output logic [DATA_W-1:0]      fl_wdata,
  input  logic                   fl_ack,
  input  logic                   fl_err,
  input  logic [DATA_W-1:0]      fl_rdata,
  output logic                   dr_req,
  output logic                   dr_we,
  output logic [HI_W+ADDR_W-1:0] dr_addr,
  output logic [DATA_W-1:0]      dr_wdata,
  input  logic                   dr_ack,
  input  logic                   dr_err,
  input  logic [DATA_W-1:0]      dr_rdata
);
  localparam int REG_W = 32;
  localparam int CNT_W = LEN_W + 1;
  localparam int STEP  = DATA_W / 8;

  // architectural state
  logic              dir_q, sum_q, done_q, err_q;
  logic              dir_n, sum_n, done_n, err_n;
  logic [ADDR_W-1:0] fl_q, fl_n, dlo_q, dlo_n;
  logic [HI_W-1:0]   dhi_q, dhi_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic [CNT_W-1:0]  rem_q, rem_n;
  logic [DATA_W-1:0] csum_q, csum_n, hold_q, hold_n;

  // control and datapath wires
  phase_e            phase;
  logic              busy, cfg_live, bad_mode, start, last;
  logic              fetch_ok, step, abort;
  logic              src_ack, src_err, dst_ack, dst_err;
  logic [DATA_W-1:0] src_data;
  logic [CNT_W-1:0]  tot_bytes, rem_dec;
  logic [HI_W-1:0]   dhi_inc;
  logic [ADDR_W-1:0] dlo_inc;

  assign busy     = (phase != PH_IDLE);
  assign cfg_live = cfg_we && !busy;
  assign bad_mode = cfg_wdata[CTL_WR] && cfg_wdata[CTL_SUM];
  assign start    = cfg_live && (cfg_wsel == SEL_CTRL) && cfg_wdata[CTL_GO] && !bad_mode;
  assign last     = (rem_q == CNT_W'(STEP));
  assign rem_dec  = rem_q - CNT_W'(STEP);

  assign src_ack  = dir_q ? dr_ack   : fl_ack;
  assign src_err  = dir_q ? dr_err   : fl_err;
  assign src_data = dir_q ? dr_rdata : fl_rdata;
  assign dst_ack  = dir_q ? fl_ack   : dr_ack;
  assign dst_err  = dir_q ? fl_err   : dr_err;

  fdma_wordcount #(.LEN_W(LEN_W), .START_LEN(START_LEN)) u_count (
    .len_i   (len_q),
    .bytes_o (tot_bytes)
  );

  fdma_addr_step #(.ADDR_W(ADDR_W), .HI_W(HI_W), .STEP(STEP)) u_dstep (
    .hi_i (dhi_q),
    .lo_i (dlo_q),
    .hi_o (dhi_inc),
    .lo_o (dlo_inc)
  );

  fdma_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .sum_only   (sum_q),
    .last       (last),
    .src_ack    (src_ack),
    .src_err    (src_err),
    .dst_ack    (dst_ack),
    .dst_err    (dst_err),
    .phase_o    (phase),
    .fetch_ok_o (fetch_ok),
    .step_o     (step),
    .abort_o    (abort)
  );

  // next-state
  always_comb begin
    dir_n  = dir_q;
    sum_n  = sum_q;
    done_n = done_q;
    err_n  = err_q;
    fl_n   = fl_q;
    dlo_n  = dlo_q;
    dhi_n  = dhi_q;
    len_n  = len_q;
    rem_n  = rem_q;
    csum_n = csum_q;
    hold_n = hold_q;

    if (cfg_live) begin
      unique case (cfg_wsel)
        SEL_CTRL: begin
          dir_n = cfg_wdata[CTL_WR];
          sum_n = cfg_wdata[CTL_SUM];
          if (cfg_wdata[CTL_GO]) begin
            done_n = 1'b0;
            csum_n = '0;
            err_n  = bad_mode;
            if (!bad_mode) rem_n = tot_bytes;
          end
        end
        SEL_FLASH: fl_n  = {cfg_wdata[ADDR_W-1:2], 2'b00};
        SEL_DLO:   dlo_n = {cfg_wdata[ADDR_W-1:2], 2'b00};
        SEL_DHI:   dhi_n = cfg_wdata[HI_W-1:0];
        SEL_LEN:   len_n = cfg_wdata[LEN_W-1:0];
        default:   ;
      endcase
    end

    if (fetch_ok) begin
      hold_n = src_data;
      csum_n = csum_q + src_data;
    end

    if (step) begin
      fl_n  = fl_q + ADDR_W'(STEP);
      rem_n = rem_dec;
      len_n = rem_dec[LEN_W-1:0];
      if (!sum_q) begin
        dlo_n = dlo_inc;
        dhi_n = dhi_inc;
      end
      if (last) done_n = 1'b1;
    end

    if (abort) err_n = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      sum_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      fl_q   <= '0;
      dlo_q  <= '0;
      dhi_q  <= '0;
      len_q  <= '0;
      rem_q  <= '0;
      csum_q <= '0;
      hold_q <= '0;
    end else begin
      dir_q  <= dir_n;
      sum_q  <= sum_n;
      done_q <= done_n;
      err_q  <= err_n;
      fl_q   <= fl_n;
      dlo_q  <= dlo_n;
      dhi_q  <= dhi_n;
      len_q  <= len_n;
      rem_q  <= rem_n;
      csum_q <= csum_n;
      hold_q <= hold_n;
    end
  end

  // memory ports
  assign fl_req   = ((phase == PH_FETCH) && !dir_q) || ((phase == PH_STORE) && dir_q);
  assign dr_req   = ((phase == PH_FETCH) && dir_q)  || ((phase == PH_STORE) && !dir_q);
  assign fl_we    = (phase == PH_STORE);
  assign dr_we    = (phase == PH_STORE);
  assign fl_addr  = fl_q;
  assign dr_addr  = {dhi_q, dlo_q};
  assign fl_wdata = hold_q;
  assign dr_wdata = hold_q;

  // register readback
  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_rsel)
      SEL_CTRL: begin
        cfg_rdata[ST_BUSY] = busy;
        cfg_rdata[ST_ERR]  = err_q;
        cfg_rdata[ST_DONE] = done_q;
        cfg_rdata[CTL_WR]  = dir_q;
        cfg_rdata[CTL_SUM] = sum_q;
      end
      SEL_FLASH: cfg_rdata = REG_W'(fl_q);
      SEL_DLO:   cfg_rdata = REG_W'(dlo_q);
      SEL_DHI:   cfg_rdata = REG_W'(dhi_q);
      SEL_LEN:   cfg_rdata = REG_W'(len_q);
      SEL_SUM:   cfg_rdata = REG_W'(csum_q);
      default:   cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fdma_checker.sv
module fdma_checker #(
  parameter int ADDR_W = 32,
  parameter int HI_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              sum_mode,
  input logic              dir_wr,
  input logic              fl_req,
  input logic              fl_we,
  input logic              fl_ack,
  input logic              fl_err,
  input logic              dr_req,
  input logic              dr_ack,
  input logic              dr_err,
  input logic [ADDR_W-1:0] dlo,
  input logic [HI_W-1:0]   dhi
);
  localparam logic [ADDR_W-1:0] LO_TOP = {ADDR_W{1'b1}} << 2;

  assert_one_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_req && dr_req));

  assert_sum_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sum_mode) |-> (!dr_req && !(fl_req && fl_we)));

  assert_carry_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !sum_mode && ($past(dlo) == LO_TOP) && (dlo == '0))
      |-> (dhi == $past(dhi) + 1'b1));

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_no_bad_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(sum_mode && dir_wr));

  assert_abort_stops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((fl_req && fl_ack && fl_err) || (dr_req && dr_ack && dr_err)) |=> (!busy && err));
endmodule

bind fdma_engine fdma_checker #(.ADDR_W(ADDR_W), .HI_W(HI_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done_q),
  .err      (err_q),
  .sum_mode (sum_q),
  .dir_wr   (dir_q),
  .fl_req   (fl_req),
  .fl_we    (fl_we),
  .fl_ack   (fl_ack),
  .fl_err   (fl_err),
  .dr_req   (dr_req),
  .dr_ack   (dr_ack),
  .dr_err   (dr_err),
  .dlo      (dlo_q),
  .dhi      (dhi_q)
);

// File: tb/fdma_engine_tb_top.sv
`timescale 1ns/1ps
module fdma_engine_tb_top;
  import fdma_pkg::*;

  localparam int START = 1;

  logic        clk, rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_wsel, cfg_rsel;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        fl_req, fl_we, fl_ack, fl_err;
  logic [31:0] fl_addr, fl_wdata, fl_rdata;
  logic        dr_req, dr_we, dr_ack, dr_err;
  logic [35:0] dr_addr;
  logic [31:0] dr_wdata, dr_rdata;

  fdma_engine #(.START_LEN(START)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_wsel(cfg_wsel), .cfg_wdata(cfg_wdata),
    .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .fl_req(fl_req), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_ack(fl_ack), .fl_err(fl_err), .fl_rdata(fl_rdata),
    .dr_req(dr_req), .dr_we(dr_we), .dr_addr(dr_addr), .dr_wdata(dr_wdata),
    .dr_ack(dr_ack), .dr_err(dr_err), .dr_rdata(dr_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int err_at = -1;
  int dr_cnt = 0;
  int req_cnt = 0;

  logic [31:0] fmem [256];
  logic [31:0] dmem [256];

  function automatic logic [31:0] fpat(int i);
    return 32'h1357_9BDF ^ (32'(i) * 32'h0101_0103);
  endfunction
  function automatic logic [31:0] dpat(int i);
    return 32'hC3C3_0000 + 32'(i) * 32'h0001_0205;
  endfunction

  task automatic mem_init();
    for (int i = 0; i < 256; i++) begin
      fmem[i] = fpat(i);
      dmem[i] = dpat(i);
    end
  endtask

  // memory models answer each request cycle, driven away from the active edge
  always @(negedge clk) begin
    fl_ack = fl_req;
    fl_err = 1'b0;
    if (fl_req) begin
      if (fl_we) fmem[fl_addr[9:2]] = fl_wdata;
      fl_rdata = fmem[fl_addr[9:2]];
    end
    dr_ack = dr_req;
    dr_err = dr_req && (dr_cnt == err_at);
    if (dr_req) begin
      if (dr_we && !dr_err) dmem[dr_addr[9:2]] = dr_wdata;
      dr_rdata = dmem[dr_addr[9:2]];
      dr_cnt++;
    end
    if (fl_req || dr_req) req_cnt++;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wsel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] v);
    @(negedge clk);
    cfg_rsel = sel;
    #1 v = cfg_rdata;
  endtask

  task automatic wait_idle(input int max_cyc);
    logic [31:0] s;
    for (int c = 0; c < max_cyc; c++) begin
      rd(SEL_CTRL, s);
      if (!s[31]) return;
    end
    check(1'b0, "R10 run never finished", 64'(s), 64'h100);
  endtask

  // stimulus/expected table: length, write dir, checksum mode, flash, dram low, dram high
  localparam int NV = 7;
  localparam logic [31:0] VL [NV] = '{32'd0, 32'd3, 32'd4, 32'd15, 32'd30, 32'd63, 32'd11};
  localparam logic        VW [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic        VS [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [31:0] VF [NV] = '{32'h100, 32'h200, 32'h300, 32'h010, 32'h380, 32'h000, 32'h040};
  localparam logic [31:0] VD [NV] = '{32'h040, 32'h080, 32'h0C0, 32'h3F0, 32'h200, 32'h300, 32'hFFFF_FFF8};
  localparam logic [3:0]  VH [NV] = '{4'd0, 4'd0, 4'd1, 4'd2, 4'd0, 4'd2, 4'd3};

  task automatic run_vec(input int v);
    logic [31:0] rv, prev, s, csum_exp;
    logic [35:0] d0, dexp;
    int nw, rb, si, di;
    bit first, prog_ok, data_ok, fin;
    string dtag;
    mem_init();
    err_at = -1;
    dr_cnt = 0;
    wr(SEL_FLASH, VF[v]);
    wr(SEL_DLO, VD[v]);
    wr(SEL_DHI, 32'(VH[v]));
    wr(SEL_LEN, VL[v]);
    wr(SEL_CTRL, 32'h8000_0000 | (32'(VW[v]) << 1) | 32'(VS[v]));
    nw = (int'(VL[v]) + START + 3) / 4;   // R3 word count
    rb = nw * 4;
    prev = VL[v]; first = 1; prog_ok = 1; fin = 0;
    for (int c = 0; c < 3000 && !fin; c++) begin
      rd(SEL_LEN, rv);
      if (rv != prev) begin
        if (first) prog_ok &= (rv < 32'(rb)) && (((32'(rb) - rv) % 4) == 0);
        else       prog_ok &= (rv == prev - 32'd4);
        first = 0;
        prev = rv;
      end
      if (rv == 0) begin
        rd(SEL_CTRL, s);
        if (!s[31]) fin = 1;
      end
    end
    check(fin, "R10 run completes", 64'(fin), 64'd1);
    check(prog_ok, "R8 length steps down by 4 per word", 64'(prev), 64'd0);
    rd(SEL_CTRL, s);
    check(s == ((32'd1 << 8) | (32'(VW[v]) << 1) | 32'(VS[v])), "R10 status done", 64'(s), 64'h100);
    rd(SEL_LEN, rv);
    check(rv == 0, "R8 length ends at zero", 64'(rv), 64'd0);
    rd(SEL_FLASH, rv);
    check(rv == VF[v] + 32'(rb), "R3 flash address advanced by word count", 64'(rv), 64'(VF[v] + 32'(rb)));
    d0 = {VH[v], VD[v]};
    dexp = VS[v] ? d0 : d0 + 36'(rb);
    rd(SEL_DLO, rv);
    check(rv == dexp[31:0], (v == 6) ? "R9 dram low after carry" : "R8 dram low", 64'(rv), 64'(dexp[31:0]));
    rd(SEL_DHI, rv);
    check(rv == 32'(dexp[35:32]), (v == 6) ? "R9 dram high after carry" : "R8 dram high", 64'(rv), 64'(dexp[35:32]));
    si = VW[v] ? int'(VD[v][9:2]) : int'(VF[v][9:2]);
    di = VW[v] ? int'(VF[v][9:2]) : int'(VD[v][9:2]);
    csum_exp = '0;
    data_ok = 1;
    for (int i = 0; i < nw; i++) begin
      logic [31:0] w;
      w = VW[v] ? dpat((si + i) % 256) : fpat((si + i) % 256);
      csum_exp += w;
      if (!VS[v]) begin
        if (VW[v]) data_ok &= (fmem[(di + i) % 256] == w);
        else       data_ok &= (dmem[(di + i) % 256] == w);
      end
    end
    rd(SEL_SUM, rv);
    check(rv == csum_exp, "R7 checksum", 64'(rv), 64'(csum_exp));
    if (VS[v]) check(dr_cnt == 0, "R6 no dram access in checksum mode", 64'(dr_cnt), 64'd0);
    else begin
      dtag = VW[v] ? "R5 dram to flash data" : "R4 flash to dram data";
      check(data_ok, dtag, 64'(data_ok), 64'd1);
    end
  endtask

  initial begin
    #800000;
    check(1'b0, "R10 watchdog expired", 64'd0, 64'd1);
    report();
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int req0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wsel = '0; cfg_wdata = '0; cfg_rsel = '0;
    fl_ack = 1'b0; fl_err = 1'b0; fl_rdata = '0;
    dr_ack = 1'b0; dr_err = 1'b0; dr_rdata = '0;
    mem_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), rv);
      check(rv == 0, "R1 register zero after reset", 64'(rv), 64'd0);
    end
    check(req_cnt == 0, "R1 no request after reset", 64'(req_cnt), 64'd0);

    // R2: write masks
    wr(SEL_FLASH, 32'hFFFF_FFFF); rd(SEL_FLASH, rv);
    check(rv == 32'hFFFF_FFFC, "R2 flash address mask", 64'(rv), 64'hFFFF_FFFC);
    wr(SEL_DLO, 32'h0000_1237); rd(SEL_DLO, rv);
    check(rv == 32'h0000_1234, "R2 dram low mask", 64'(rv), 64'h1234);
    wr(SEL_DHI, 32'h0000_00FF); rd(SEL_DHI, rv);
    check(rv == 32'h0000_000F, "R2 dram high mask", 64'(rv), 64'hF);
    wr(SEL_LEN, 32'hFFFF_FFFF); rd(SEL_LEN, rv);
    check(rv == 32'h01FF_FFFF, "R2 length mask", 64'(rv), 64'h1FF_FFFF);

    // table walk: R3 R4 R5 R6 R7 R8, vector 6 wraps the low dram word for R9
    for (int v = 0; v < NV; v++) run_vec(v);

    // R11: illegal mode after a completed run; go also clears done and checksum
    req0 = req_cnt;
    wr(SEL_CTRL, 32'h8000_0003);
    repeat (5) @(negedge clk);
    rd(SEL_CTRL, rv);
    check(rv == 32'h0000_0203, "R11 illegal mode sets error, no busy, done cleared", 64'(rv), 64'h203);
    rd(SEL_SUM, rv);
    check(rv == 0, "R7 checksum cleared by go", 64'(rv), 64'd0);
    check(req_cnt == req0, "R11 no memory request", 64'(req_cnt), 64'(req0));

    // R12: dram write of the second word fails
    mem_init();
    dr_cnt = 0; err_at = 1;
    wr(SEL_FLASH, 32'h40); wr(SEL_DLO, 32'h80); wr(SEL_DHI, 32'h0); wr(SEL_LEN, 32'd15);
    wr(SEL_CTRL, 32'h8000_0000);
    repeat (40) @(negedge clk);
    err_at = -1;
    rd(SEL_CTRL, rv);
    check(rv == 32'h0000_0200, "R12 abort sets error without done", 64'(rv), 64'h200);
    rd(SEL_LEN, rv);
    check(rv == 32'd12, "R12 length holds last completed word", 64'(rv), 64'd12);
    rd(SEL_FLASH, rv);
    check(rv == 32'h44, "R12 flash address holds", 64'(rv), 64'h44);
    rd(SEL_DLO, rv);
    check(rv == 32'h84, "R12 dram address holds", 64'(rv), 64'h84);
    check(dmem[8'h20] == fpat(8'h10) && dmem[8'h21] == dpat(8'h21), "R12 failed word not stored",
          64'(dmem[8'h21]), 64'(dpat(8'h21)));

    // R13: register writes during a run are ignored
    mem_init();
    wr(SEL_FLASH, 32'h100); wr(SEL_DLO, 32'h100); wr(SEL_DHI, 32'h0); wr(SEL_LEN, 32'd63);
    wr(SEL_CTRL, 32'h8000_0000);
    wr(SEL_LEN, 32'd0);
    wr(SEL_FLASH, 32'h800);
    wr(SEL_CTRL, 32'h8000_0001);
    wait_idle(500);
    rd(SEL_FLASH, rv);
    check(rv == 32'h140, "R13 flash address unaffected by busy writes", 64'(rv), 64'h140);
    rd(SEL_CTRL, rv);
    check(rv == 32'h0000_0100, "R13 mode unaffected by busy go", 64'(rv), 64'h100);
    rd(SEL_LEN, rv);
    check(rv == 0, "R13 length unaffected by busy write", 64'(rv), 64'd0);

    report();
    $finish;
  end
endmodule